// File: doc/BRIEF.md
# Two-Approach Signal Phase Sequencer

This block drives the lamps of a crossing where two road approaches meet and pedestrians cross. Each approach gets a turn made of a through-and-right green, a yellow, a red-with-left-arrow interval and a second yellow. After that the other approach takes its own turn, and its lamps follow the mirror of the same order. A pedestrian phase is added only when someone has pressed the crossing button. It holds both roads red through a walk interval and then a blinking interval. The phase is placed at the end of the cycle, once both approaches have had their turn.

An external timing unit decides how long each green and each left-arrow interval lasts. It raises `sw` when the current one should end. Yellow, walk and blink intervals are timed inside the block by counting pulses of the real-time `tick` strobe. The block pulses `phaseDone` whenever a new green, left-arrow or walk phase begins, so the timing unit can restart its phase timer. `armSel` chooses which approach gets green first when the machine leaves its initial state.

Top module: `tl_sequencer`

## Requirements
- R1: While reset is asserted, and in the clock after `clear` is sampled high, both lamp outputs read 2'b00 (red), `pedLamp` reads 2'b00 (don't walk) and `phaseDone` is 0.
- R2: One clock after leaving the initial state, the lamps show approach 1 green (`arm1Lamp`=2'b01, `arm2Lamp`=2'b00) if `armSel` was 0, and approach 2 green (`arm2Lamp`=2'b01, `arm1Lamp`=2'b00) if it was 1.
- R3: A green (2'b01) or left-arrow (2'b11) lamp holds for as long as `sw` is sampled 0. It ends at the clock edge that samples `sw`=1, whatever `tick` does.
- R4: Each turn runs green 2'b01, yellow 2'b10, left arrow 2'b11, yellow 2'b10, and then passes to the other approach's green. The approach that is not in its turn stays red 2'b00 throughout, so both lamps are never non-red at once.
- R5: Each yellow lasts exactly YELLOW_TICKS (default 2) `tick` pulses. It ends at the edge that samples the last of them. Clocks with `tick` low do not count.
- R6: A `pedBtn` press is latched. It is served only when the turn of the approach that did not start the cycle ends, and never in the middle of the cycle.
- R7: The pedestrian phase holds both lamps red. `pedLamp`=2'b01 (walk) lasts WALK_TICKS (default 10) ticks, then `pedLamp`=2'b10 (blink) lasts BLINK_TICKS (default 5) ticks. The cycle then restarts with the green of the approach that started it.
- R8: The pending request is dropped when the walk begins. A press during walk or blink is ignored, so the next cycle end brings no pedestrian phase.
- R9: `phaseDone` is high for exactly one clock, the first clock of every green, left-arrow and walk interval, and is low otherwise.
- R10: `clear` in the middle of a cycle returns the machine to the initial state and drops any pending pedestrian request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous return to the initial state |
| tick | input | 1 | Real-time tick strobe, one clock wide |
| sw | input | 1 | End request for the current green or left-arrow interval |
| armSel | input | 1 | Approach that gets green first (0: approach 1, 1: approach 2) |
| pedBtn | input | 1 | Pedestrian button |
| arm1Lamp | output | 2 | Approach 1 lamp: 00 red, 01 green, 10 yellow, 11 red + left arrow |
| arm2Lamp | output | 2 | Approach 2 lamp, same encoding |
| pedLamp | output | 2 | 00 don't walk, 01 walk, 10 blink |
| phaseDone | output | 1 | One-clock pulse at the start of each green, left-arrow and walk interval |

## Verification
The bench targets the points where a near-miss design would still look plausible. A press made early in the cycle must not take effect until the end of the cycle; a design that served it at once would cut the second approach's turn. Yellow and walk must not end one tick early or late, and clocks without a tick must not be counted. A press during walk must not make the next cycle repeat the walk. A clear must not leave a stale request behind. The bench also runs a long random stream of switch, tick, button and clear inputs for both starting approaches. It compares every output on every clock against an arithmetic model of the phase order.

// File: rtl/tl_pkg.sv
package tl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_G1    = 4'd1,
    ST_Y1A   = 4'd2,
    ST_L1    = 4'd3,
    ST_Y1B   = 4'd4,
    ST_G2    = 4'd5,
    ST_Y2A   = 4'd6,
    ST_L2    = 4'd7,
    ST_Y2B   = 4'd8,
    ST_WALK  = 4'd9,
    ST_FLASH = 4'd10
  } phase_e;

  typedef enum logic [1:0] {
    TMR_AMBER = 2'd0,
    TMR_WALK  = 2'd1,
    TMR_FLASH = 2'd2
  } tmrSel_e;

  localparam logic [1:0] LAMP_RED   = 2'b00;
  localparam logic [1:0] LAMP_GO    = 2'b01;
  localparam logic [1:0] LAMP_AMBER = 2'b10;
  localparam logic [1:0] LAMP_ARROW = 2'b11;

  localparam logic [1:0] PED_WAIT  = 2'b00;
  localparam logic [1:0] PED_WALK  = 2'b01;
  localparam logic [1:0] PED_FLASH = 2'b10;

  typedef struct packed {
    logic    tmrRestart;
    tmrSel_e tmrSel;
    logic    pedTake;
    logic    pedBlock;
    logic    armLoad;
  } ctlStrobe_t;

endpackage

// File: rtl/tl_dp.sv
module tl_dp
  import tl_pkg::*;
#(
  parameter int YELLOW_TICKS = 2,
  parameter int WALK_TICKS   = 10,
  parameter int BLINK_TICKS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  logic       pedBtn,
  input  logic       armSel,
  input  ctlStrobe_t strb,
  output logic       tmrExpire,
  output logic       pedPending,
  output logic       startArm
);

  localparam int MAX_T = (YELLOW_TICKS > WALK_TICKS)
                       ? ((YELLOW_TICKS > BLINK_TICKS) ? YELLOW_TICKS : BLINK_TICKS)
                       : ((WALK_TICKS > BLINK_TICKS) ? WALK_TICKS : BLINK_TICKS);
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] AMBER_LAST = CNT_W'(YELLOW_TICKS - 1);
  localparam logic [CNT_W-1:0] WALK_LAST  = CNT_W'(WALK_TICKS - 1);
  localparam logic [CNT_W-1:0] FLASH_LAST = CNT_W'(BLINK_TICKS - 1);

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] lastCnt;

  always_comb begin
    case (strb.tmrSel)
      TMR_WALK:  lastCnt = WALK_LAST;
      TMR_FLASH: lastCnt = FLASH_LAST;
      default:   lastCnt = AMBER_LAST;
    endcase
  end

  // interval counter: restarts on every state change, saturates while idle-holding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tickCnt <= '0;
    else if (clear || strb.tmrRestart)   tickCnt <= '0;
    else if (tick && (tickCnt != '1))    tickCnt <= tickCnt + 1'b1;
  end

  assign tmrExpire = tick && (tickCnt == lastCnt);

  // pedestrian request latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          pedPending <= 1'b0;
    else if (clear || strb.pedTake)      pedPending <= 1'b0;
    else if (pedBtn && !strb.pedBlock)   pedPending <= 1'b1;
  end

  // approach that opens the cycle, captured while in the initial state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            startArm <= 1'b0;
    else if (strb.armLoad) startArm <= armSel;
  end

endmodule

// File: rtl/tl_ctrl.sv
module tl_ctrl
  import tl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       sw,
  input  logic       armSel,
  input  logic       tmrExpire,
  input  logic       pedPending,
  input  logic       startArm,
  output ctlStrobe_t strb,
  output logic [1:0] arm1Lamp,
  output logic [1:0] arm2Lamp,
  output logic [1:0] pedLamp,
  output logic       phaseDone
);

  phase_e state, nxt;
  logic   entersTimed;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  nxt = armSel ? ST_G2 : ST_G1;
      ST_G1:    if (sw) nxt = ST_Y1A;
      ST_Y1A:   if (tmrExpire) nxt = ST_L1;
      ST_L1:    if (sw) nxt = ST_Y1B;
      ST_Y1B:   if (tmrExpire) nxt = (startArm && pedPending) ? ST_WALK : ST_G2;
      ST_G2:    if (sw) nxt = ST_Y2A;
      ST_Y2A:   if (tmrExpire) nxt = ST_L2;
      ST_L2:    if (sw) nxt = ST_Y2B;
      ST_Y2B:   if (tmrExpire) nxt = (!startArm && pedPending) ? ST_WALK : ST_G1;
      ST_WALK:  if (tmrExpire) nxt = ST_FLASH;
      ST_FLASH: if (tmrExpire) nxt = startArm ? ST_G2 : ST_G1;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= ST_IDLE;
    else if (clear) state <= ST_IDLE;
    else            state <= nxt;
  end

  always_comb begin
    strb.tmrRestart = (nxt != state);
    case (state)
      ST_WALK:  strb.tmrSel = TMR_WALK;
      ST_FLASH: strb.tmrSel = TMR_FLASH;
      default:  strb.tmrSel = TMR_AMBER;
    endcase
    strb.pedTake  = (nxt == ST_WALK) && (state != ST_WALK);
    strb.pedBlock = (state == ST_WALK) || (state == ST_FLASH);
    strb.armLoad  = (state == ST_IDLE);
  end

  assign entersTimed = (nxt == ST_G1) || (nxt == ST_L1) || (nxt == ST_G2) ||
                       (nxt == ST_L2) || (nxt == ST_WALK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phaseDone <= 1'b0;
    else if (clear) phaseDone <= 1'b0;
    else            phaseDone <= (nxt != state) && entersTimed;
  end

  always_comb begin
    arm1Lamp = LAMP_RED;
    arm2Lamp = LAMP_RED;
    pedLamp  = PED_WAIT;
    case (state)
      ST_G1:          arm1Lamp = LAMP_GO;
      ST_Y1A, ST_Y1B: arm1Lamp = LAMP_AMBER;
      ST_L1:          arm1Lamp = LAMP_ARROW;
      ST_G2:          arm2Lamp = LAMP_GO;
      ST_Y2A, ST_Y2B: arm2Lamp = LAMP_AMBER;
      ST_L2:          arm2Lamp = LAMP_ARROW;
      ST_WALK:        pedLamp  = PED_WALK;
      ST_FLASH:       pedLamp  = PED_FLASH;
      default:        ;
    endcase
  end

endmodule

// File: rtl/tl_sequencer.sv
module tl_sequencer
  import tl_pkg::*;
#(
  parameter int YELLOW_TICKS = 2,
  parameter int WALK_TICKS   = 10,
  parameter int BLINK_TICKS  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  logic       sw,
  input  logic       armSel,
  input  logic       pedBtn,
  output logic [1:0] arm1Lamp,
  output logic [1:0] arm2Lamp,
  output logic [1:0] pedLamp,
  output logic       phaseDone
);

  ctlStrobe_t strb;
  logic       tmrExpire;
  logic       pedPending;
  logic       startArm;

  tl_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .sw         (sw),
    .armSel     (armSel),
    .tmrExpire  (tmrExpire),
    .pedPending (pedPending),
    .startArm   (startArm),
    .strb       (strb),
    .arm1Lamp   (arm1Lamp),
    .arm2Lamp   (arm2Lamp),
    .pedLamp    (pedLamp),
    .phaseDone  (phaseDone)
  );

  tl_dp #(
    .YELLOW_TICKS (YELLOW_TICKS),
    .WALK_TICKS   (WALK_TICKS),
    .BLINK_TICKS  (BLINK_TICKS)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .tick       (tick),
    .pedBtn     (pedBtn),
    .armSel     (armSel),
    .strb       (strb),
    .tmrExpire  (tmrExpire),
    .pedPending (pedPending),
    .startArm   (startArm)
  );

endmodule

// File: rtl/tl_sequencer_chk.sv
module tl_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clear,
  input logic       tick,
  input logic       sw,
  input logic [1:0] arm1Lamp,
  input logic [1:0] arm2Lamp,
  input logic [1:0] pedLamp,
  input logic       phaseDone
);

  // R4
  lamps_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((arm1Lamp != 2'b00) && (arm2Lamp != 2'b00)));

  // R7
  ped_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pedLamp != 2'b00) |-> ((arm1Lamp == 2'b00) && (arm2Lamp == 2'b00)));

  // R3
  green_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm1Lamp == 2'b01) && !sw && !clear) |=> (arm1Lamp == 2'b01));

  // R3
  arrow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm2Lamp == 2'b11) && !sw && !clear) |=> (arm2Lamp == 2'b11));

  // R5
  amber_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm1Lamp == 2'b10) && !tick && !clear) |=> (arm1Lamp == 2'b10));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phaseDone |=> !phaseDone);

  // R1
  clear_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ((arm1Lamp == 2'b00) && (arm2Lamp == 2'b00) &&
               (pedLamp == 2'b00) && !phaseDone));

endmodule

bind tl_sequencer tl_sequencer_chk u_chk (.*);

// File: tb/tb_tl_sequencer.sv
module tb_tl_sequencer;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clear = 1'b0;
  logic tick = 1'b0;
  logic sw = 1'b0;
  logic armSel = 1'b0;
  logic pedBtn = 1'b0;
  logic [1:0] arm1Lamp, arm2Lamp, pedLamp;
  logic phaseDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // bench model of the phase order
  int mPh = 0, mCnt = 0;
  bit mPend = 0, mStart = 0, mDone = 0;

  always #2.5 clk = ~clk;

  tl_sequencer dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(tick), .sw(sw),
    .armSel(armSel), .pedBtn(pedBtn), .arm1Lamp(arm1Lamp),
    .arm2Lamp(arm2Lamp), .pedLamp(pedLamp), .phaseDone(phaseDone)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] lampsOf(input int ph);
    logic [1:0] a1 = 2'b00, a2 = 2'b00, p = 2'b00;
    case (ph)
      1: a1 = 2'b01;  2, 4: a1 = 2'b10;  3: a1 = 2'b11;
      5: a2 = 2'b01;  6, 8: a2 = 2'b10;  7: a2 = 2'b11;
      9: p = 2'b01;   10: p = 2'b10;
      default: ;
    endcase
    return {a1, a2, p};
  endfunction

  task automatic modelStep();
    int nph = mPh;
    bit expire;
    int last = (mPh == 9) ? 10 : (mPh == 10) ? 5 : 2;
    expire = tick && (mCnt == last - 1);
    if (mPh == 0) mStart = armSel;
    if (clear) begin
      mPh = 0; mCnt = 0; mPend = 0; mDone = 0;
      return;
    end
    case (mPh)
      0: nph = armSel ? 5 : 1;
      1: if (sw) nph = 2;
      2: if (expire) nph = 3;
      3: if (sw) nph = 4;
      4: if (expire) nph = (mStart && mPend) ? 9 : 5;
      5: if (sw) nph = 6;
      6: if (expire) nph = 7;
      7: if (sw) nph = 8;
      8: if (expire) nph = (!mStart && mPend) ? 9 : 1;
      9: if (expire) nph = 10;
      10: if (expire) nph = mStart ? 5 : 1;
      default: nph = 0;
    endcase
    if (nph == 9 && mPh != 9) mPend = 0;
    else if (pedBtn && mPh != 9 && mPh != 10) mPend = 1;
    mDone = (nph != mPh) && (nph == 1 || nph == 3 || nph == 5 || nph == 7 || nph == 9);
    mCnt = (nph != mPh) ? 0 : (tick ? mCnt + 1 : mCnt);
    mPh = nph;
  endtask

  task automatic step(input logic s, input logic t, input logic p);
    sw = s; tick = t; pedBtn = p;
    modelStep();
    @(posedge clk);
    #1;
    chk("R4 lamps vs model", {4'h0, arm1Lamp, arm2Lamp}, {4'h0, lampsOf(mPh)[5:2]});
    chk("R7 pedLamp vs model", {6'h0, pedLamp}, {6'h0, lampsOf(mPh)[1:0]});
    chk("R9 phaseDone vs model", {7'h0, phaseDone}, {7'h0, mDone});
    sw = 0; tick = 0; pedBtn = 0;
  endtask

  // one full turn of an approach: green, yellow, arrow, yellow
  task automatic turn();
    step(1, 0, 0); step(0, 1, 0); step(0, 1, 0);
    step(1, 0, 0); step(0, 1, 0); step(0, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 lamps in reset", {4'h0, arm1Lamp, arm2Lamp}, 8'h00);
    chk("R1 ped in reset", {6'h0, pedLamp}, 8'h00);
    chk("R1 done in reset", {7'h0, phaseDone}, 8'h00);
    rst_n = 1'b1;

    step(0, 0, 0);
    chk("R2 arm1 first", {4'h0, arm1Lamp, arm2Lamp}, 8'h04);
    chk("R9 done on green", {7'h0, phaseDone}, 8'h01);
    repeat (4) step(0, 1, 0);
    chk("R3 green held", {6'h0, arm1Lamp}, 8'h01);
    chk("R9 done single", {7'h0, phaseDone}, 8'h00);
    step(1, 0, 0);
    chk("R4 yellow after green", {6'h0, arm1Lamp}, 8'h02);
    step(0, 1, 0);
    chk("R5 yellow after 1 tick", {6'h0, arm1Lamp}, 8'h02);
    repeat (3) step(0, 0, 0);
    chk("R5 no tick no count", {6'h0, arm1Lamp}, 8'h02);
    step(0, 1, 0);
    chk("R5 arrow after 2 ticks", {6'h0, arm1Lamp}, 8'h03);
    step(0, 0, 1);
    step(1, 0, 0); step(0, 1, 0); step(0, 1, 0);
    chk("R6 no mid-cycle walk", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h04);
    turn();
    chk("R6 walk at cycle end", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h01);
    step(0, 1, 1);
    repeat (8) step(0, 1, 0);
    chk("R7 walk for 9 ticks", {6'h0, pedLamp}, 8'h01);
    step(0, 1, 0);
    chk("R7 blink after 10", {6'h0, pedLamp}, 8'h02);
    repeat (4) step(0, 1, 0);
    chk("R7 blink for 4 ticks", {6'h0, pedLamp}, 8'h02);
    step(0, 1, 0);
    chk("R7 back to arm1 green", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h10);
    turn(); turn();
    chk("R8 press in walk ignored", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h10);

    step(0, 0, 1);
    clear = 1'b1;
    step(0, 0, 0);
    clear = 1'b0;
    chk("R10 clear to init", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h00);
    armSel = 1'b1;
    step(0, 0, 0);
    chk("R2 arm2 first", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h04);
    turn(); turn();
    chk("R10 request dropped", {2'b0, arm1Lamp, arm2Lamp, pedLamp}, 8'h04);

    // random sweep against the model, both starting approaches
    for (int i = 0; i < 6000; i++) begin
      armSel = 1'($urandom_range(0, 1));
      clear  = ($urandom_range(0, 399) == 0);
      step(($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 24) == 0));
      clear = 1'b0;
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule